// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside a 32-bit adder/subtractor. On each arithmetic step it receives the two operands, the operation code, the carry-in and the result that the datapath produced. From these it derives six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It holds them in a 32-bit flags word together with a direction bit and an interrupt-enable bit.

Each of the two control bits has its own set and clear strobes. The whole word can be reloaded in one cycle from a saved copy, which is how a save/restore of processor status is carried out. The current word is always visible on the output port, so a save is just a read of that port.

Flags use the usual two's-complement conventions. Subtraction reports a borrow in the carry flag. Auxiliary carry looks at the boundary between bits 3 and 4. Parity looks only at the low byte of the result.

Top module: `status_flag_unit`

## Requirements
- R1: After reset the flags word reads 0x0000_0002. Bit 1 always reads one, and every bit other than 0, 1, 2, 4, 6, 7, 9, 10 and 11 always reads zero.
- R2: For add (op 2'b00) and add-with-carry (op 2'b01), the carry flag (bit 0) is set when the unsigned sum a + b + c exceeds 32 bits. Here c is cin for add-with-carry and 0 for add, so cin is ignored by plain add.
- R3: For subtract (op 2'b10) and subtract-with-borrow (op 2'b11), the carry flag (bit 0) is set when a < b + c unsigned. Here c is cin for subtract-with-borrow and 0 for subtract, so cin is ignored by plain subtract.
- R4: The parity flag (bit 2) is set when result bits 7:0 hold an even number of ones.
- R5: The auxiliary carry flag (bit 4) is set on a carry out of bit 3 (add ops) or a borrow into bit 3 (subtract ops). It uses the same carry-in rule as R2/R3.
- R6: The zero flag (bit 6) is set exactly when the result is all zeros.
- R7: The sign flag (bit 7) equals result bit 31.
- R8: The overflow flag (bit 11) is set when the signed result of the operation falls outside the 32-bit two's-complement range.
- R9: The direction bit (bit 10) is set by dir_set and cleared by dir_clr, and clear wins when both are high. An arithmetic update leaves it unchanged.
- R10: The interrupt-enable bit (bit 9) is set by ie_set and cleared by ie_clr, and clear wins when both are high. An arithmetic update leaves it unchanged.
- R11: With restore_en high, every defined bit is loaded from restore_word on the next edge, while bit 1 stays one and the undefined bits stay zero. Restore takes priority over an update and over any set or clear strobe in the same cycle.
- R12: With no strobe high, the flags word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Capture arithmetic flags from this cycle's operands and result |
| op | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| cin | input | 1 | Carry/borrow input, used by op 01 and 11 only |
| opa | input | 32 | First operand (minuend for subtract) |
| opb | input | 32 | Second operand (subtrahend for subtract) |
| res | input | 32 | Result produced by the adder/subtractor |
| dir_set | input | 1 | Set the direction bit |
| dir_clr | input | 1 | Clear the direction bit |
| ie_set | input | 1 | Set the interrupt-enable bit |
| ie_clr | input | 1 | Clear the interrupt-enable bit |
| restore_en | input | 1 | Load the flags word from restore_word |
| restore_word | input | 32 | Saved flags word to reload |
| flags_word | output | 32 | Current flags word |

## Verification
Every result is registered once. A strobe presented before a rising edge is therefore visible on flags_word right after that edge, and all flags are due exactly one cycle after their stimulus. The bench changes inputs just after a falling edge and samples flags_word at the following falling edge, half a period after the capturing edge. It then drops the strobes before the next rising edge, so each stimulus acts on exactly one edge. Hold and priority cases are checked the same way: an idle cycle, or a restore combined with an update and a clear, is followed by a sample one falling edge later.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam int unsigned FLAG_W = 32;

    // Fixed bit positions in the flags word
    localparam int unsigned POS_CF  = 0;
    localparam int unsigned POS_ONE = 1;
    localparam int unsigned POS_PF  = 2;
    localparam int unsigned POS_AF  = 4;
    localparam int unsigned POS_ZF  = 6;
    localparam int unsigned POS_SF  = 7;
    localparam int unsigned POS_IE  = 9;
    localparam int unsigned POS_DIR = 10;
    localparam int unsigned POS_OF  = 11;

    localparam logic [FLAG_W-1:0] DEFINED_MASK = 32'h0000_0ED5;
    localparam logic [FLAG_W-1:0] FIXED_ONES   = 32'h0000_0002;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } arith_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } arith_flags_t;

    // Control bits kept as a small vector so both are built by one generate
    localparam int unsigned CTRL_N  = 2;
    localparam int unsigned CT_IE   = 0;
    localparam int unsigned CT_DIR  = 1;

    typedef struct packed {
        arith_flags_t            ar;
        logic [CTRL_N-1:0]       ct;
    } flag_state_t;

    localparam flag_state_t STATE_RESET = '0;

    function automatic logic is_sub(arith_op_e o);
        return o[1];
    endfunction

    function automatic logic uses_cin(arith_op_e o);
        return o[0];
    endfunction

    function automatic logic even_ones8(logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic [FLAG_W-1:0] pack_state(flag_state_t s);
        logic [FLAG_W-1:0] w;
        w = FIXED_ONES;
        w[POS_CF]  = s.ar.cry;
        w[POS_PF]  = s.ar.par;
        w[POS_AF]  = s.ar.aux;
        w[POS_ZF]  = s.ar.zro;
        w[POS_SF]  = s.ar.sgn;
        w[POS_OF]  = s.ar.ovf;
        w[POS_IE]  = s.ct[CT_IE];
        w[POS_DIR] = s.ct[CT_DIR];
        return w;
    endfunction

    function automatic flag_state_t unpack_word(logic [FLAG_W-1:0] w);
        flag_state_t s;
        s.ar.cry      = w[POS_CF];
        s.ar.par      = w[POS_PF];
        s.ar.aux      = w[POS_AF];
        s.ar.zro      = w[POS_ZF];
        s.ar.sgn      = w[POS_SF];
        s.ar.ovf      = w[POS_OF];
        s.ct[CT_IE]   = w[POS_IE];
        s.ct[CT_DIR]  = w[POS_DIR];
        return s;
    endfunction

endpackage

// File: rtl/sfg_arith_eval.sv
module sfg_arith_eval
    import sfg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  arith_op_e           op,
    input  logic                cin,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [DATA_W-1:0]   res,
    output arith_flags_t        flags
);
    localparam int unsigned MSB = DATA_W - 1;
    localparam int unsigned NIB = 4;

    logic              sub;
    logic              c_eff;
    logic [NIB-1:0]    a_lo;
    logic [NIB-1:0]    b_lo;
    logic [NIB-1:0]    b_lo_n;
    logic [DATA_W-1:0] b_n;
    logic              add_cry;
    logic              sub_brw;
    logic              add_aux;
    logic              sub_aux;
    logic              sgn_a;
    logic              sgn_b;
    logic              sgn_r;

    assign sub    = is_sub(op);
    assign c_eff  = uses_cin(op) & cin;
    assign a_lo   = opa[NIB-1:0];
    assign b_lo   = opb[NIB-1:0];
    assign b_n    = ~opb;
    assign b_lo_n = ~b_lo;
    assign sgn_a  = opa[MSB];
    assign sgn_b  = opb[MSB];
    assign sgn_r  = res[MSB];

    // a + b + c carries out exactly when a exceeds (all-ones - b - c)
    assign add_cry = c_eff ? (opa >= b_n)    : (opa > b_n);
    // a - b - c borrows exactly when a is below b + c
    assign sub_brw = c_eff ? (opa <= opb)    : (opa < opb);
    assign add_aux = c_eff ? (a_lo >= b_lo_n) : (a_lo > b_lo_n);
    assign sub_aux = c_eff ? (a_lo <= b_lo)  : (a_lo < b_lo);

    always_comb begin
        flags.cry = sub ? sub_brw : add_cry;
        flags.aux = sub ? sub_aux : add_aux;
        flags.zro = (res == '0);
        flags.sgn = sgn_r;
        flags.par = even_ones8(res[7:0]);
        if (sub) begin
            flags.ovf = (sgn_a != sgn_b) && (sgn_r != sgn_a);
        end else begin
            flags.ovf = (sgn_a == sgn_b) && (sgn_r != sgn_a);
        end
    end

endmodule

// File: rtl/sfg_ctrl_next.sv
module sfg_ctrl_next
    import sfg_pkg::*;
#(
    parameter int unsigned NBITS = CTRL_N
) (
    input  logic [NBITS-1:0] cur,
    input  logic [NBITS-1:0] set_req,
    input  logic [NBITS-1:0] clr_req,
    output logic [NBITS-1:0] nxt
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_comb begin
            if (clr_req[i]) begin
                nxt[i] = 1'b0;
            end else if (set_req[i]) begin
                nxt[i] = 1'b1;
            end else begin
                nxt[i] = cur[i];
            end
        end
    end

endmodule

// File: rtl/sfg_word_reg.sv
module sfg_word_reg
    import sfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restore_en,
    input  logic [FLAG_W-1:0]    restore_word,
    input  logic                 upd_en,
    input  arith_flags_t         ar_new,
    input  logic [CTRL_N-1:0]    ct_new,
    output flag_state_t          state
);
    flag_state_t state_d;

    always_comb begin
        state_d = state;
        if (restore_en) begin
            state_d = unpack_word(restore_word);
        end else begin
            if (upd_en) begin
                state_d.ar = ar_new;
            end
            state_d.ct = ct_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= STATE_RESET;
        end else begin
            state <= state_d;
        end
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [1:0]        op,
    input  logic              cin,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    input  logic              dir_set,
    input  logic              dir_clr,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              restore_en,
    input  logic [31:0]       restore_word,
    output logic [31:0]       flags_word
);
    arith_flags_t       ar_calc;
    flag_state_t        state;
    logic [CTRL_N-1:0]  ct_set;
    logic [CTRL_N-1:0]  ct_clr;
    logic [CTRL_N-1:0]  ct_nxt;

    sfg_arith_eval #(.DATA_W(DATA_W)) u_eval (
        .op    (arith_op_e'(op)),
        .cin   (cin),
        .opa   (opa),
        .opb   (opb),
        .res   (res),
        .flags (ar_calc)
    );

    always_comb begin
        ct_set         = '0;
        ct_clr         = '0;
        ct_set[CT_DIR] = dir_set;
        ct_clr[CT_DIR] = dir_clr;
        ct_set[CT_IE]  = ie_set;
        ct_clr[CT_IE]  = ie_clr;
    end

    sfg_ctrl_next #(.NBITS(CTRL_N)) u_ctrl (
        .cur     (state.ct),
        .set_req (ct_set),
        .clr_req (ct_clr),
        .nxt     (ct_nxt)
    );

    sfg_word_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .restore_en   (restore_en),
        .restore_word (restore_word),
        .upd_en       (upd_en),
        .ar_new       (ar_calc),
        .ct_new       (ct_nxt),
        .state        (state)
    );

    assign flags_word = pack_state(state);

endmodule

// File: rtl/sfg_chk.sv
module sfg_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         upd_en,
    input logic         op_sub,
    input logic         a_msb,
    input logic         b_msb,
    input logic [W-1:0] res,
    input logic         dir_set,
    input logic         dir_clr,
    input logic         ie_set,
    input logic         ie_clr,
    input logic         restore_en,
    input logic [31:0]  restore_word,
    input logic [31:0]  flags_word
);
    logic quiet;
    assign quiet = !upd_en && !dir_set && !dir_clr && !ie_set && !ie_clr && !restore_en;

    // R1
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        flags_word[1] && ((flags_word & ~32'h0000_0ED7) == 32'h0));

    // R4
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !restore_en |=> flags_word[2] == ($countones($past(res[7:0])) % 2 == 0));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !restore_en |=> flags_word[6] == ($past(res) == '0));

    // R7
    sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !restore_en |=> flags_word[7] == $past(res[W-1]));

    // R8
    overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !restore_en |=> flags_word[11] ==
            ($past(op_sub) ? (($past(a_msb) != $past(b_msb)) && ($past(res[W-1]) != $past(a_msb)))
                           : (($past(a_msb) == $past(b_msb)) && ($past(res[W-1]) != $past(a_msb)))));

    // R9
    dir_set_chk: assert property (@(posedge clk) disable iff (rst)
        dir_set && !dir_clr && !restore_en |=> flags_word[10]);

    // R9
    dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
        dir_clr && !restore_en |=> !flags_word[10]);

    // R10
    ie_set_chk: assert property (@(posedge clk) disable iff (rst)
        ie_set && !ie_clr && !restore_en |=> flags_word[9]);

    // R10
    ie_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ie_clr && !restore_en |=> !flags_word[9]);

    // R11
    restore_word_chk: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> flags_word == (($past(restore_word) & 32'h0000_0ED5) | 32'h0000_0002));

    // R12
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(flags_word));

endmodule

bind status_flag_unit sfg_chk #(.W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .upd_en       (upd_en),
    .op_sub       (op[1]),
    .a_msb        (opa[DATA_W-1]),
    .b_msb        (opb[DATA_W-1]),
    .res          (res),
    .dir_set      (dir_set),
    .dir_clr      (dir_clr),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .restore_en   (restore_en),
    .restore_word (restore_word),
    .flags_word   (flags_word)
);

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;

    localparam int B_CF = 0, B_PF = 2, B_AF = 4, B_ZF = 6, B_SF = 7, B_IE = 9, B_DIR = 10, B_OF = 11;
    localparam int NV = 12;

    // {op, cin, opa, opb}; op 00 add, 01 adc, 10 sub, 11 sbb
    localparam logic [66:0] VEC [NV] = '{
        {2'b00, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001},
        {2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
        {2'b10, 1'b0, 32'h0000_0000, 32'h0000_0001},
        {2'b10, 1'b0, 32'h8000_0000, 32'h0000_0001},
        {2'b01, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        {2'b11, 1'b1, 32'h0000_0005, 32'h0000_0004},
        {2'b11, 1'b1, 32'h0000_0005, 32'h0000_0005},
        {2'b00, 1'b1, 32'h0000_000F, 32'h0000_0001},
        {2'b10, 1'b1, 32'h0000_0010, 32'h0000_0001},
        {2'b01, 1'b0, 32'h8000_0000, 32'h8000_0000},
        {2'b10, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
        {2'b00, 1'b0, 32'h0000_0003, 32'h0000_0004}
    };

    logic        clk = 1'b0;
    logic        rst, upd_en, cin, dir_set, dir_clr, ie_set, ie_clr, restore_en;
    logic [1:0]  op;
    logic [31:0] opa, opb, res, restore_word, flags_word;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    status_flag_unit u0 (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op(op), .cin(cin),
        .opa(opa), .opb(opb), .res(res),
        .dir_set(dir_set), .dir_clr(dir_clr), .ie_set(ie_set), .ie_clr(ie_clr),
        .restore_en(restore_en), .restore_word(restore_word), .flags_word(flags_word)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference flags worked out from the requirements with wide arithmetic
    task automatic ref_flags(input logic [1:0] o, input logic ci, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] r, output logic cf, output logic pf, output logic af,
                             output logic zf, output logic sf, output logic of);
        int     c;
        longint sa, sb, sr;
        logic [32:0] wide;
        c  = (o[0] && ci) ? 1 : 0;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!o[1]) begin
            wide = {1'b0, a} + {1'b0, b} + 33'(c);
            cf   = wide[32];
            af   = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
            sr   = sa + sb + longint'(c);
            r    = wide[31:0];
        end else begin
            cf   = longint'(a) < (longint'(b) + longint'(c));
            af   = int'(a[3:0]) < (int'(b[3:0]) + c);
            sr   = sa - sb - longint'(c);
            r    = a - b - 32'(c);
        end
        of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        zf = (r == 32'h0);
        sf = r[31];
        pf = ($countones(r[7:0]) % 2) == 0;
    endtask

    task automatic idle_inputs();
        upd_en = 0; dir_set = 0; dir_clr = 0; ie_set = 0; ie_clr = 0; restore_en = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, w;
        logic cf, pf, af, zf, sf, of;
        logic [1:0] vo;
        logic vc;
        logic [31:0] va, vb;

        rst = 1; idle_inputs();
        op = 0; cin = 0; opa = 0; opb = 0; res = 0; restore_word = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset value", flags_word, 32'h0000_0002);

        // Vector table: one update per entry, flags checked one edge later
        for (int i = 0; i < NV; i++) begin
            {vo, vc, va, vb} = VEC[i];
            ref_flags(vo, vc, va, vb, r, cf, pf, af, zf, sf, of);
            op = vo; cin = vc; opa = va; opb = vb; res = r; upd_en = 1;
            step();
            chk(vo[1] ? "R3 borrow flag" : "R2 carry flag", 32'(flags_word[B_CF]), 32'(cf));
            chk("R4 parity flag", 32'(flags_word[B_PF]), 32'(pf));
            chk("R5 aux carry flag", 32'(flags_word[B_AF]), 32'(af));
            chk("R6 zero flag", 32'(flags_word[B_ZF]), 32'(zf));
            chk("R7 sign flag", 32'(flags_word[B_SF]), 32'(sf));
            chk("R8 overflow flag", 32'(flags_word[B_OF]), 32'(of));
            chk("R1 fixed bits", flags_word & ~32'h0000_0ED5, 32'h0000_0002);
        end

        // R9 direction set, update keeps it, clear wins over set
        w = flags_word;
        dir_set = 1; step();
        chk("R9 dir set", flags_word, w | 32'h0000_0400);
        ref_flags(2'b00, 1'b0, 32'h0000_0080, 32'h0000_0080, r, cf, pf, af, zf, sf, of);
        op = 2'b00; cin = 0; opa = 32'h80; opb = 32'h80; res = r; upd_en = 1; step();
        chk("R9 dir kept by update", 32'(flags_word[B_DIR]), 32'd1);
        chk("R7 sign after dir", 32'(flags_word[B_SF]), 32'(sf));
        dir_set = 1; dir_clr = 1; step();
        chk("R9 clear wins", 32'(flags_word[B_DIR]), 32'd0);

        // R10 interrupt enable
        ie_set = 1; step();
        chk("R10 ie set", 32'(flags_word[B_IE]), 32'd1);
        upd_en = 1; step();
        chk("R10 ie kept by update", 32'(flags_word[B_IE]), 32'd1);
        ie_set = 1; ie_clr = 1; step();
        chk("R10 clear wins", 32'(flags_word[B_IE]), 32'd0);

        // R11 restore, with competing strobes in the same cycle
        restore_word = 32'hFFFF_FFFF; restore_en = 1; upd_en = 1; dir_clr = 1; ie_clr = 1;
        op = 2'b00; opa = 32'h3; opb = 32'h4; res = 32'h7; step();
        chk("R11 restore all ones", flags_word, 32'h0000_0ED7);
        restore_word = 32'h0000_0000; restore_en = 1; dir_set = 1; ie_set = 1; step();
        chk("R11 restore zero", flags_word, 32'h0000_0002);
        restore_word = 32'h0000_0A55; restore_en = 1; step();
        chk("R11 restore pattern", flags_word, 32'h0000_0A57);

        // R12 hold with no strobe
        w = flags_word;
        opa = 32'hDEAD_BEEF; opb = 32'h1234_5678; res = 32'h0; restore_word = 32'h0;
        repeat (3) step();
        chk("R12 hold", flags_word, w);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule